// File: doc/BRIEF.md
# Per-Pin Edge Sense and Interrupt Unit

This unit watches a bank of 32 already-synchronised input pins and turns selected transitions on them into sticky event flags. Each pin owns a two-bit sensitivity code that picks rising-only, falling-only, both-edge or no detection. The codes for the lower half of the pins live in one control register and the codes for the upper half in a second one. Events collect in a register that software clears by writing ones. A mask register decides which events may raise the single combined interrupt line.

Next to the interrupt, the unit presents the number of the highest pending, unmasked pin with a valid flag, so an interrupt handler can dispatch without scanning the event register. A direction register sits in the same register space. Its top four pins are hard-wired as inputs, so their direction bits cannot be set.

All registers use MSB-first pin numbering: pin p occupies register bit 31-p. On the pin input bus, pin p is `pins_in[p]`. Writes take effect at the rising clock edge. Reads are combinational from the current register contents.

Top module: `pin_sense_unit`

## Requirements
- R1: After reset, the direction (0x00), event (0x0C), mask (0x10) and both sensitivity registers (0x14, 0x18) read zero, and `irq` and `pend_valid` are low.
- R2: Pins 0..15 take their sensitivity code from the register at 0x14 and pins 16..31 from the register at 0x18. Pin p's code sits at bits [(15-(p mod 16))*2+1 : (15-(p mod 16))*2].
- R3: Code 1 latches an event on a low-to-high change of the pin and ignores high-to-low. The event bit reads set after the first clock edge that samples the new level.
- R4: Code 2 latches an event on a high-to-low change and ignores low-to-high.
- R5: Code 0 latches an event on either change. A pin that holds its level latches nothing.
- R6: Code 3 latches no event on any change.
- R7: The event register holds pin p at bit 31-p and is sticky. A written 1 clears that bit and a written 0 leaves it unchanged. If a detection and a clear hit the same bit in the same cycle, the bit stays set.
- R8: The mask register holds pin p at bit 31-p. `irq` is high exactly when some pin has both its event bit and its mask bit set.
- R9: `pend_valid` equals `irq`. While it is high, `pend_idx` gives the highest pin number whose event and mask bits are both set.
- R10: In the direction register (0x00), the bits of pins 28..31 (bits 3..0) always read 0, and writes to them are ignored. Bits 31..4 store what is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pins_in | input | 32 | Synchronised pin levels, pin p on bit p |
| irq | output | 1 | Combined interrupt |
| pend_valid | output | 1 | A masked event is pending |
| pend_idx | output | 5 | Highest pending unmasked pin number |

## Verification
The bench goes after the field placement by using pins 0, 15, 16 and 31, which sit at the outer ends of both control registers. A design that packed the fields LSB-first or swapped the two registers would latch events on the wrong pins. It checks both transition directions for every code, so a design that swapped the rising and falling codes, or treated code 3 as both-edge, latches events on the wrong transitions. It drives a detection in the same cycle as a clear of that bit, which catches a design that gives the clear priority and drops the event. It also checks that the priority encoder reports pin 29 over pin 3, which exposes a design that returns the lowest pin or the raw register bit number.

// File: rtl/psu_pkg.sv
package psu_pkg;

   typedef enum logic [1:0] {
      SNS_BOTH = 2'd0,
      SNS_RISE = 2'd1,
      SNS_FALL = 2'd2,
      SNS_OFF  = 2'd3
   } sense_e;

   // Lowest bit of a pin's two-bit field inside its half-bank register.
   function automatic int unsigned fld_lsb(int unsigned pin, int unsigned per_reg);
      return (per_reg - 1 - (pin % per_reg)) * 2;
   endfunction

   // Register image with a 1 for every pin below first_ro (MSB-first order).
   function automatic logic [63:0] dir_wmask(int unsigned n, int unsigned first_ro);
      logic [63:0] m;
      m = '0;
      for (int unsigned p = 0; p < n; p++)
         if (p < first_ro) m[n-1-p] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/psu_cfg_regs.sv
module psu_cfg_regs
   import psu_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned RO_FIRST = 28,
   parameter logic [ADDR_W-1:0] DIR_OFF  = 5'h00,
   parameter logic [ADDR_W-1:0] MASK_OFF = 5'h10,
   parameter logic [ADDR_W-1:0] SNSA_OFF = 5'h14,
   parameter logic [ADDR_W-1:0] SNSB_OFF = 5'h18
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   dir_img,
   output logic [DATA_W-1:0]   mask_img,
   output logic [DATA_W-1:0]   snsa_img,
   output logic [DATA_W-1:0]   snsb_img,
   output logic [DATA_W-1:0]   mask_pin,
   output logic [2*DATA_W-1:0] sns_pin
);
   localparam int unsigned N_PINS  = DATA_W;
   localparam int unsigned PER_REG = DATA_W / 2;
   localparam logic [63:0] WM64    = dir_wmask(N_PINS, RO_FIRST);
   localparam logic [DATA_W-1:0] DIR_WM = WM64[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_img <= '0;
         snsa_img <= '0;
         snsb_img <= '0;
      end else if (wr_en) begin
         if (addr == MASK_OFF) mask_img <= wdata;
         if (addr == SNSA_OFF) snsa_img <= wdata;
         if (addr == SNSB_OFF) snsb_img <= wdata;
      end
   end

   generate
      if (RO_FIRST < N_PINS) begin : g_ro_top
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          dir_img <= '0;
            else if (wr_en && addr == DIR_OFF)   dir_img <= wdata & DIR_WM;
         end
      end else begin : g_all_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          dir_img <= '0;
            else if (wr_en && addr == DIR_OFF)   dir_img <= wdata;
         end
      end

      for (genvar p = 0; p < N_PINS; p++) begin : g_pin
         localparam int unsigned LSB = fld_lsb(p, PER_REG);
         assign mask_pin[p] = mask_img[N_PINS-1-p];
         if (p < PER_REG) begin : g_lo
            assign sns_pin[2*p +: 2] = snsa_img[LSB +: 2];
         end else begin : g_hi
            assign sns_pin[2*p +: 2] = snsb_img[LSB +: 2];
         end
      end
   endgenerate
endmodule

// File: rtl/psu_edge_det.sv
module psu_edge_det
   import psu_pkg::*;
#(
   parameter int unsigned N_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_PINS-1:0]   pins_in,
   input  logic [2*N_PINS-1:0] sns_pin,
   output logic [N_PINS-1:0]   hit
);
   logic [N_PINS-1:0] prev;
   logic              armed;

   // The first sampled level after reset only primes the history.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= '0;
         armed <= 1'b0;
      end else begin
         prev  <= pins_in;
         armed <= 1'b1;
      end
   end

   generate
      for (genvar p = 0; p < N_PINS; p++) begin : g_pin
         logic   h;
         logic   up, dn;
         sense_e code;
         assign code = sense_e'(sns_pin[2*p +: 2]);
         assign up   = armed &  pins_in[p] & ~prev[p];
         assign dn   = armed & ~pins_in[p] &  prev[p];
         always_comb begin
            case (code)
               SNS_RISE: h = up;
               SNS_FALL: h = dn;
               SNS_BOTH: h = up | dn;
               default:  h = 1'b0;
            endcase
         end
         assign hit[p] = h;
      end
   endgenerate
endmodule

// File: rtl/psu_evt_pend.sv
module psu_evt_pend #(
   parameter int unsigned N_PINS = 32,
   parameter int unsigned IDX_W  = $clog2(N_PINS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] hit,
   input  logic [N_PINS-1:0] clr_pin,
   input  logic [N_PINS-1:0] mask_pin,
   output logic [N_PINS-1:0] evt_pin,
   output logic              irq,
   output logic              pend_valid,
   output logic [IDX_W-1:0]  pend_idx
);
   logic [N_PINS-1:0] act;

   // A detection in the clearing cycle survives the clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_pin <= '0;
      else        evt_pin <= (evt_pin & ~clr_pin) | hit;
   end

   assign act = evt_pin & mask_pin;
   assign irq = |act;

   always_comb begin
      pend_valid = 1'b0;
      pend_idx   = '0;
      for (int i = 0; i < N_PINS; i++) begin
         if (act[i]) begin
            pend_valid = 1'b1;
            pend_idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/pin_sense_unit.sv
module pin_sense_unit
   import psu_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned RO_FIRST = 28,
   parameter logic [ADDR_W-1:0] DIR_OFF  = 5'h00,
   parameter logic [ADDR_W-1:0] EVT_OFF  = 5'h0C,
   parameter logic [ADDR_W-1:0] MASK_OFF = 5'h10,
   parameter logic [ADDR_W-1:0] SNSA_OFF = 5'h14,
   parameter logic [ADDR_W-1:0] SNSB_OFF = 5'h18,
   parameter int unsigned IDX_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] pins_in,
   output logic              irq,
   output logic              pend_valid,
   output logic [IDX_W-1:0]  pend_idx
);
   localparam int unsigned N_PINS = DATA_W;

   generate
      if (DATA_W < 2 || DATA_W % 2 != 0) begin : g_bad_width
         $error("pin_sense_unit: DATA_W must be even and at least 2");
      end
      if (RO_FIRST > N_PINS) begin : g_bad_ro
         $error("pin_sense_unit: RO_FIRST exceeds the pin count");
      end
      if (DATA_W > 64) begin : g_bad_max
         $error("pin_sense_unit: DATA_W above 64 is not supported");
      end
   endgenerate

   logic [DATA_W-1:0]   dir_img, mask_img, snsa_img, snsb_img, evt_img;
   logic [N_PINS-1:0]   mask_pin, hit, clr_pin, evt_pin;
   logic [2*N_PINS-1:0] sns_pin;
   logic                evt_wr;

   assign evt_wr = bus_wr && (bus_addr == EVT_OFF);

   generate
      for (genvar p = 0; p < N_PINS; p++) begin : g_map
         assign clr_pin[p]           = evt_wr & bus_wdata[N_PINS-1-p];
         assign evt_img[N_PINS-1-p]  = evt_pin[p];
      end
   endgenerate

   psu_cfg_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RO_FIRST(RO_FIRST),
      .DIR_OFF(DIR_OFF), .MASK_OFF(MASK_OFF),
      .SNSA_OFF(SNSA_OFF), .SNSB_OFF(SNSB_OFF)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .dir_img(dir_img), .mask_img(mask_img),
      .snsa_img(snsa_img), .snsb_img(snsb_img),
      .mask_pin(mask_pin), .sns_pin(sns_pin)
   );

   psu_edge_det #(.N_PINS(N_PINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .pins_in(pins_in),
      .sns_pin(sns_pin), .hit(hit)
   );

   psu_evt_pend #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .hit(hit), .clr_pin(clr_pin),
      .mask_pin(mask_pin), .evt_pin(evt_pin), .irq(irq),
      .pend_valid(pend_valid), .pend_idx(pend_idx)
   );

   always_comb begin
      if      (bus_addr == DIR_OFF)  bus_rdata = dir_img;
      else if (bus_addr == EVT_OFF)  bus_rdata = evt_img;
      else if (bus_addr == MASK_OFF) bus_rdata = mask_img;
      else if (bus_addr == SNSA_OFF) bus_rdata = snsa_img;
      else if (bus_addr == SNSB_OFF) bus_rdata = snsb_img;
      else                           bus_rdata = '0;
   end
endmodule

// File: rtl/psu_chk.sv
module psu_chk
   import psu_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned RO_FIRST = 28,
   parameter logic [ADDR_W-1:0] DIR_OFF = 5'h00,
   parameter int unsigned IDX_W    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] pins_in,
   input logic              irq,
   input logic              pend_valid,
   input logic [IDX_W-1:0]  pend_idx,
   input logic [DATA_W-1:0] evt_pin,
   input logic [DATA_W-1:0] mask_pin,
   input logic [DATA_W-1:0] clr_pin,
   input logic [DATA_W-1:0] hit
);
   localparam logic [63:0] WM64 = dir_wmask(DATA_W, RO_FIRST);
   localparam logic [DATA_W-1:0] DIR_WM = WM64[DATA_W-1:0];

   // R10
   dir_ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == DIR_OFF) |-> ((bus_rdata & ~DIR_WM) == '0));

   // R5
   evt_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_pin & ~$past(evt_pin)) & ~($past(pins_in) ^ $past(pins_in, 2))) == '0);

   // R7
   evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(evt_pin) & ~$past(clr_pin) & ~evt_pin) == '0);

   // R7
   evt_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pin & $past(clr_pin) & ~$past(hit)) == '0);

   // R8
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_pin == '0) |-> !irq);

   // R9
   pend_points_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (evt_pin[pend_idx] && mask_pin[pend_idx] && irq));
endmodule

bind pin_sense_unit psu_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RO_FIRST(RO_FIRST),
   .DIR_OFF(DIR_OFF), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .pins_in(pins_in), .irq(irq), .pend_valid(pend_valid),
   .pend_idx(pend_idx), .evt_pin(evt_pin), .mask_pin(mask_pin),
   .clr_pin(clr_pin), .hit(hit)
);

// File: tb/sim_pin_sense_unit.sv
`timescale 1ns/1ps
module sim_pin_sense_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pins_in = '0;
   logic        irq, pend_valid;
   logic [4:0]  pend_idx;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pin_sense_unit u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in),
      .irq(irq), .pend_valid(pend_valid), .pend_idx(pend_idx)
   );

   // {pin[4:0], code[1:0], old level, new level, event expected}
   localparam logic [9:0] VEC [12] = '{
      {5'd0,  2'd1, 1'b0, 1'b1, 1'b1},
      {5'd0,  2'd1, 1'b1, 1'b0, 1'b0},
      {5'd5,  2'd2, 1'b1, 1'b0, 1'b1},
      {5'd5,  2'd2, 1'b0, 1'b1, 1'b0},
      {5'd15, 2'd0, 1'b0, 1'b1, 1'b1},
      {5'd16, 2'd0, 1'b1, 1'b0, 1'b1},
      {5'd27, 2'd3, 1'b0, 1'b1, 1'b0},
      {5'd31, 2'd3, 1'b1, 1'b0, 1'b0},
      {5'd31, 2'd1, 1'b0, 1'b1, 1'b1},
      {5'd20, 2'd2, 1'b1, 1'b0, 1'b1},
      {5'd8,  2'd0, 1'b1, 1'b1, 1'b0},
      {5'd30, 2'd2, 1'b0, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(5'h00, d); chk("R1 dir", d, 32'h0);
      rd(5'h0C, d); chk("R1 evt", d, 32'h0);
      rd(5'h10, d); chk("R1 mask", d, 32'h0);
      rd(5'h14, d); chk("R1 sense A", d, 32'h0);
      rd(5'h18, d); chk("R1 sense B", d, 32'h0);
      chk("R1 irq/valid", {30'd0, irq, pend_valid}, 32'h0);

      // R2..R6 table walk
      for (int i = 0; i < 12; i++) begin
         logic [4:0]  pin;
         logic [1:0]  code;
         logic [31:0] cfg;
         int unsigned sh;
         pin  = VEC[i][9:5];
         code = VEC[i][4:3];
         sh   = (15 - (pin % 16)) * 2;
         cfg  = 32'hFFFF_FFFF & ~(32'h3 << sh);
         cfg  = cfg | (32'(code) << sh);
         wr((pin < 16) ? 5'h14 : 5'h18, cfg);
         @(negedge clk);
         pins_in[pin] = VEC[i][2];
         repeat (2) @(negedge clk);
         wr(5'h0C, 32'hFFFF_FFFF);
         pins_in[pin] = VEC[i][1];
         @(negedge clk);
         rd(5'h0C, d);
         chk($sformatf("R2/R3/R4/R5/R6 vec %0d pin %0d code %0d", i, pin, code),
             d, VEC[i][0] ? (32'h1 << (31 - pin)) : 32'h0);
      end

      // R10 direction top pins
      wr(5'h00, 32'hFFFF_FFFF);
      rd(5'h00, d); chk("R10 dir write ones", d, 32'hFFFF_FFF0);

      // R8 / R9 setup: all pins both-edge, clear events
      wr(5'h14, 32'h0);
      wr(5'h18, 32'h0);
      pins_in = '0;
      repeat (2) @(negedge clk);
      wr(5'h0C, 32'hFFFF_FFFF);
      pins_in[3]  = 1'b1;
      pins_in[29] = 1'b1;
      @(negedge clk);
      rd(5'h0C, d); chk("R7 evt msb-first", d, (32'h1 << 28) | (32'h1 << 2));
      chk("R8 irq masked off", {31'd0, irq}, 32'h0);
      wr(5'h10, 32'h1 << 28);
      chk("R8 irq one mask", {31'd0, irq}, 32'h1);
      chk("R9 idx pin3", {26'd0, pend_valid, pend_idx}, {26'd0, 1'b1, 5'd3});
      wr(5'h10, 32'hFFFF_FFFF);
      chk("R9 idx highest", {26'd0, pend_valid, pend_idx}, {26'd0, 1'b1, 5'd29});

      // R7 write zeros no effect, then selective clear
      wr(5'h0C, 32'h0);
      rd(5'h0C, d); chk("R7 zeros ignored", d, (32'h1 << 28) | (32'h1 << 2));
      wr(5'h0C, 32'h1 << 2);
      rd(5'h0C, d); chk("R7 w1c pin29", d, 32'h1 << 28);
      chk("R9 idx after clear", {26'd0, pend_valid, pend_idx}, {26'd0, 1'b1, 5'd3});

      // R7 detection beats a same-cycle clear
      @(negedge clk);
      pins_in[3] = 1'b0;
      bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h1 << 28;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(5'h0C, d); chk("R7 set wins", d, 32'h1 << 28);
      wr(5'h0C, 32'h1 << 28);
      rd(5'h0C, d); chk("R7 cleared", d, 32'h0);
      chk("R8 irq drops", {30'd0, irq, pend_valid}, 32'h0);

      summary();
   end
endmodule